// File: doc/BRIEF.md
# Pipelined Unsigned Array Multiplier

This block forms the full-width unsigned product of a multiplicand and a multiplier. It is built as a grid of conditional full-adder cells. Each cell is steered by one multiplier bit: when that bit is set, the cell adds its multiplicand bit to the running sum. When the bit is clear, the cell only passes the running sum and the carry through.

There is one row of cells per multiplier bit. Each row ends in a register, so a fresh operand pair may enter on every clock. Each pair leaves as a product a fixed number of cycles later, in the order it entered.

Registers carry three things from row to row:
- the operands that later rows still need;
- the partial sum;
- the low product bits already finished.

As a result, every row works on data from a single multiplication. A strobe travels with the data and marks which stage slots hold real work.

Top module: `mul_array_pipe`

## Requirements
- R1: For every accepted pair, `out_p` equals `in_a` × `in_b` as an unsigned number of width A_W+B_W. With the default 4×4 widths, 15 × 15 gives 225.
- R2: A pair sampled with `in_vld` high at a rising edge appears with `out_vld` high exactly B_W rising edges later. The first of those edges is the one that samples the pair, and B_W is 4 by default.
- R3: Pairs presented on consecutive cycles produce products on consecutive cycles, in the same order, with no stall between them.
- R4: A cycle with `in_vld` low yields a cycle with `out_vld` low B_W edges later. The operand values present in that cycle never produce an output.
- R5: While `rst` is high at a rising edge, every stage strobe is cleared. Pairs in flight at that moment are dropped and never appear on the output, and `out_vld` stays low until a new pair has passed through the pipeline.
- R6: If either operand is zero, the product is zero. In particular, a zero multiplier gives zero even when the multiplicand is all ones, because every row adds only the running sum and carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the stage strobes |
| in_vld | input | 1 | Marks `in_a`/`in_b` as a pair to multiply |
| in_a | input | A_W | Multiplicand |
| in_b | input | B_W | Multiplier |
| out_vld | output | 1 | Marks `out_p` as a finished product |
| out_p | output | A_W+B_W | Unsigned product |

## Verification
The assertions assume that `rst` is high at the first clock edge. They also assume that the operand inputs hold known values whenever `in_vld` is high. Operand values in idle cycles may be anything, because the checker's reference delay line only compares products in cycles flagged as valid. The bench holds reset from time zero and drives defined operands with every strobe. It also parks the operands at defined values during bubbles, so the zero-operand and product checks only ever look at real pairs.

// File: rtl/mul_array_pkg.sv
package mul_array_pkg;

    typedef struct packed {
        logic cout;
        logic s;
    } cell_res_t;

    // Conditional full adder: the multiplier bit z gates the multiplicand bit x
    function automatic cell_res_t cell_eval(input logic x, input logic y,
                                            input logic z, input logic ci);
        cell_res_t r;
        logic      xg;
        xg     = x & z;
        r.s    = xg ^ y ^ ci;
        r.cout = (xg & y) | (xg & ci) | (y & ci);
        return r;
    endfunction

endpackage

// File: rtl/mul_cell.sv
module mul_cell
    import mul_array_pkg::*;
(
    input  logic x,
    input  logic y,
    input  logic z,
    input  logic ci,
    output logic s,
    output logic co
);
    cell_res_t res;

    always_comb begin
        res = cell_eval(x, y, z, ci);
        s   = res.s;
        co  = res.cout;
    end
endmodule

// File: rtl/mul_row.sv
module mul_row #(
    parameter int A_W = 4
) (
    input  logic [A_W-1:0] mcand,
    input  logic [A_W-1:0] psum,
    input  logic           mbit,
    output logic [A_W-1:0] sum,
    output logic           cout
);
    logic [A_W:0] carry;

    assign carry[0] = 1'b0;

    for (genvar j = 0; j < A_W; j++) begin : g_cell
        mul_cell u_cell (
            .x  (mcand[j]),
            .y  (psum[j]),
            .z  (mbit),
            .ci (carry[j]),
            .s  (sum[j]),
            .co (carry[j+1])
        );
    end

    assign cout = carry[A_W];
endmodule

// File: rtl/mul_array_pipe.sv
module mul_array_pipe #(
    parameter int A_W = 4,
    parameter int B_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_vld,
    input  logic [A_W-1:0]     in_a,
    input  logic [B_W-1:0]     in_b,
    output logic               out_vld,
    output logic [A_W+B_W-1:0] out_p
);
    localparam int LAT = B_W;

    typedef struct packed {
        logic           vld;
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
        logic [A_W-1:0] acc;
        logic [B_W-1:0] lo;
    } stage_t;

    stage_t         src   [LAT];
    stage_t         stg_d [LAT];
    stage_t         stg_q [LAT];
    logic [A_W-1:0] row_sum  [LAT];
    logic           row_cout [LAT];
    logic [A_W:0]   row_wide [LAT];

    for (genvar i = 0; i < LAT; i++) begin : g_row
        if (i == 0) begin : g_head
            assign src[i] = '{vld: in_vld, a: in_a, b: in_b, acc: '0, lo: '0};
        end else begin : g_link
            assign src[i] = stg_q[i-1];
        end

        mul_row #(.A_W(A_W)) u_row (
            .mcand (src[i].a),
            .psum  (src[i].acc),
            .mbit  (src[i].b[i]),
            .sum   (row_sum[i]),
            .cout  (row_cout[i])
        );

        assign row_wide[i] = {row_cout[i], row_sum[i]};
    end

    always_comb begin
        for (int i = 0; i < LAT; i++) begin
            stg_d[i]       = src[i];
            stg_d[i].acc   = row_wide[i][A_W:1];
            stg_d[i].lo[i] = row_wide[i][0];
        end
    end

    always_ff @(posedge clk) begin
        stg_q <= stg_d;
        if (rst) begin
            for (int i = 0; i < LAT; i++) begin
                stg_q[i].vld <= 1'b0;
            end
        end
    end

    assign out_vld = stg_q[LAT-1].vld;
    assign out_p   = {stg_q[LAT-1].acc, stg_q[LAT-1].lo};

    logic unused_tail;
    assign unused_tail = ^{stg_q[LAT-1].a, stg_q[LAT-1].b};
endmodule

// File: rtl/mul_array_pipe_chk.sv
module mul_array_pipe_chk #(
    parameter int A_W = 4,
    parameter int B_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               in_vld,
    input logic [A_W-1:0]     in_a,
    input logic [B_W-1:0]     in_b,
    input logic               out_vld,
    input logic [A_W+B_W-1:0] out_p
);
    localparam int LAT = B_W;
    localparam int PW  = A_W + B_W;

    logic [LAT-1:0] vline;
    logic [LAT-1:0] zline;
    logic [PW-1:0]  pline [LAT];

    always_ff @(posedge clk) begin
        vline[0] <= rst ? 1'b0 : in_vld;
        zline[0] <= (in_a == '0) || (in_b == '0);
        pline[0] <= PW'(in_a) * PW'(in_b);
        for (int i = 1; i < LAT; i++) begin
            vline[i] <= rst ? 1'b0 : vline[i-1];
            zline[i] <= zline[i-1];
            pline[i] <= pline[i-1];
        end
    end

    a_r1_product: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> out_p == pline[LAT-1]);

    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        vline[LAT-1] |-> out_vld);

    a_r4_bubble: assert property (@(posedge clk) disable iff (rst)
        !vline[LAT-1] |-> !out_vld);

    a_r5_flush: assert property (@(posedge clk)
        rst |=> !out_vld);

    a_r6_zero: assert property (@(posedge clk) disable iff (rst)
        (out_vld && zline[LAT-1]) |-> out_p == '0);
endmodule

bind mul_array_pipe mul_array_pipe_chk #(.A_W(A_W), .B_W(B_W)) u_chk (.*);

// File: tb/tb_mul_array_pipe.sv
`timescale 1ns/1ps
module tb_mul_array_pipe;
    localparam int A_W = 4;
    localparam int B_W = 4;
    localparam int LAT = B_W;
    localparam int PW  = A_W + B_W;

    // {a, b, expected product}
    localparam logic [15:0] VEC [16] = '{
        {4'd3,  4'd5,  8'd15},  {4'd15, 4'd15, 8'd225}, {4'd0,  4'd9,  8'd0},
        {4'd15, 4'd0,  8'd0},   {4'd1,  4'd1,  8'd1},   {4'd8,  4'd8,  8'd64},
        {4'd7,  4'd9,  8'd63},  {4'd10, 4'd11, 8'd110}, {4'd1,  4'd15, 8'd15},
        {4'd15, 4'd1,  8'd15},  {4'd12, 4'd13, 8'd156}, {4'd6,  4'd6,  8'd36},
        {4'd9,  4'd14, 8'd126}, {4'd2,  4'd8,  8'd16},  {4'd0,  4'd0,  8'd0},
        {4'd11, 4'd7,  8'd77}
    };

    typedef struct {
        logic [PW-1:0] p;
        int            due;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_vld = 1'b0;
    logic [A_W-1:0] in_a = '0;
    logic [B_W-1:0] in_b = '0;
    logic           out_vld;
    logic [PW-1:0]  out_p;

    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    exp_t q[$];

    mul_array_pipe #(.A_W(A_W), .B_W(B_W)) dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_a(in_a), .in_b(in_b),
        .out_vld(out_vld), .out_p(out_p)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                checks++;
                if (out_vld !== 1'b1) begin
                    fails++;
                    $display("FAIL R2 out_vld actual=%b expected=1 cyc=%0d", out_vld, cyc);
                end
                checks++;
                if (out_p !== q[0].p) begin
                    fails++;
                    $display("FAIL R1 out_p actual=%0d expected=%0d", out_p, q[0].p);
                end
                void'(q.pop_front());
            end else if (out_vld !== 1'b0) begin
                checks++;
                fails++;
                $display("FAIL R4 out_vld actual=%b expected=0 cyc=%0d", out_vld, cyc);
            end
        end
    end

    task automatic drive(input logic [A_W-1:0] a, input logic [B_W-1:0] b);
        exp_t e;
        @(negedge clk);
        in_vld = 1'b1;
        in_a   = a;
        in_b   = b;
        e.p    = PW'(a) * PW'(b);
        e.due  = cyc + LAT;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_vld = 1'b0;
            in_a   = 4'hF;
            in_b   = 4'hF;
        end
    endtask

    task automatic expect_low(input string tag);
        checks++;
        if (out_vld !== 1'b0) begin
            fails++;
            $display("FAIL %s out_vld actual=%b expected=0", tag, out_vld);
        end
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R5: reset state
        repeat (3) @(negedge clk);
        expect_low("R5");
        rst = 1'b0;

        // R1 R3 R6: table vectors back to back; check table against product too
        for (int k = 0; k < 16; k++) begin
            checks++;
            if (PW'(VEC[k][15:12]) * PW'(VEC[k][11:8]) != VEC[k][7:0]) begin
                fails++;
                $display("FAIL R1 table entry %0d actual=%0d expected=%0d", k,
                         VEC[k][7:0], PW'(VEC[k][15:12]) * PW'(VEC[k][11:8]));
            end
            drive(VEC[k][15:12], VEC[k][11:8]);
        end
        idle(LAT + 2);

        // R4: bubbles between pairs, operands in bubbles must not appear
        for (int k = 0; k < 6; k++) begin
            drive(4'(k + 3), 4'(13 - k));
            idle(1 + (k % 2));
        end
        idle(LAT + 2);

        // R1 R3: every operand pair, back to back
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                drive(4'(a), 4'(b));
            end
        end
        idle(LAT + 2);

        // R5: reset with pairs in flight drops them
        drive(4'd9, 4'd9);
        drive(4'd5, 4'd7);
        @(negedge clk);
        rst    = 1'b1;
        in_vld = 1'b0;
        q.delete();
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < LAT + 2; k++) begin
            @(negedge clk);
            expect_low("R5");
        end

        // R2: recovery after reset, then all expected outputs consumed
        drive(4'd15, 4'd15);
        idle(LAT + 2);
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R2 pending results actual=%0d expected=0", q.size());
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule